// File: doc/BRIEF.md
# Sampled parallel-load serial-output shift register

This block holds a row of storage stages that can be filled from a parallel word and then emptied, one bit per shift, through a serial output. A complementary copy of the serial output is also provided. It runs entirely on a fast system clock. The external shift clock, clock-inhibit, active-low load strobe, serial fill bit and parallel word are treated as slow asynchronous signals. They are resynchronised and then evaluated as sampled logic.

A shift is triggered by a rising edge of the gated clock, which is the OR of the shift clock and the inhibit. Either input can therefore act as the clock while the other holds it off. A low load strobe is level-sensitive: it keeps copying the parallel word into the stages for as long as it stays low, and it overrides any shift. Typical use is reading a bank of switches or status lines into a serial link. The stages are loaded, the strobe is released, and the clock is pulsed once per bit.

Top module: `psr_shreg`

## Requirements
- R1: While `rst` is high and after it falls, all stages read zero, `q_out` is 0 and `q_out_n` is 1. No shift is taken after reset merely because the shift clock or inhibit input is already high.
- R2: While `load_n` (as seen after synchronisation) is low, every stage continuously follows `par_in`, whatever the shift clock, inhibit or serial input do. Bit `par_in[WIDTH-1]` lands in the output stage.
- R3: While `load_n` is high, changes on `par_in` leave the stages and outputs untouched.
- R4: With `load_n` high and the inhibit low, a low-to-high change of the shift clock causes exactly one shift.
- R5: With `load_n` high and the shift clock low, a low-to-high change of the inhibit also causes exactly one shift.
- R6: With `load_n` high and either the shift clock or the inhibit held high, toggling the other input causes no shift.
- R7: A shift moves every stage one place toward the output stage, and `ser_in` enters stage 0. After a load, successive shifts present `par_in[WIDTH-1]`, `par_in[WIDTH-2]`, down to `par_in[0]` at `q_out`, followed by the serial fill bits.
- R8: `q_out_n` is always the inverse of `q_out`.
- R9: An input change that is stable before system clock edge k first shows at the outputs after edge k+SYNC_STAGES. For the default of two stages, this is the third edge.
- R10: When a gated-clock rising edge and a low `load_n` are seen in the same system cycle, the load is applied and the shift is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | External shift clock, asynchronous |
| inhib_in | input | 1 | External clock inhibit, asynchronous, interchangeable with sclk_in |
| load_n_in | input | 1 | Active-low level-sensitive parallel load, asynchronous |
| ser_in | input | 1 | Serial fill bit for stage 0 |
| par_in | input | WIDTH | Parallel word; bit WIDTH-1 goes to the output stage |
| q_out | output | 1 | Output stage (serial data out), registered |
| q_out_n | output | 1 | Inverse of q_out, registered |

## Verification
The assertions assume that every external input stays stable long enough to pass through the synchroniser. A bit that is sampled once must still be valid on the next sampling cycle. They also assume that the shift clock and inhibit do not both change in a way that hides an edge inside one system cycle. The stimulus changes inputs only on falling system clock edges and holds each shift-clock or inhibit level for four system cycles. The single exception is the deliberate one-cycle load pulse used for the load-versus-shift collision. The synchroniser delays all inputs equally, so that pulse still lines up with the clock edge inside the block.

// File: rtl/psr_pkg.sv
package psr_pkg;

  // Default depth of the input resynchroniser.
  localparam int unsigned SYNC_DEFAULT = 2;

  // What the stage row does in a given system cycle.
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_SHIFT = 2'd2
  } stage_op_e;

  // Load is level-sensitive and has priority over a detected shift edge.
  function automatic stage_op_e pick_op(input logic ld_n, input logic shift_ev);
    if (!ld_n)         return OP_LOAD;
    else if (shift_ev) return OP_SHIFT;
    else               return OP_HOLD;
  endfunction

endpackage

// File: rtl/psr_sync.sv
module psr_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] pipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe[0] <= RST_VAL;
        else     pipe[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= RST_VAL;
        else     pipe[g] <= pipe[g-1];
      end
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/psr_gate_edge.sv
module psr_gate_edge (
  input  logic clk,
  input  logic rst,
  input  logic sclk_s,
  input  logic inhib_s,
  output logic shift_ev
);

  logic gate;
  logic gate_hist;

  // Either input may act as the clock; the other holds it off.
  assign gate = sclk_s | inhib_s;

  // History resets high: a gate already high after reset is not an edge.
  always_ff @(posedge clk) begin
    if (rst) gate_hist <= 1'b1;
    else     gate_hist <= gate;
  end

  assign shift_ev = gate & ~gate_hist;

endmodule

// File: rtl/psr_stages.sv
module psr_stages
  import psr_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  stage_op_e        op,
  input  logic             ser,
  input  logic [WIDTH-1:0] par,
  output logic [WIDTH-1:0] stg,
  output logic             tail,
  output logic             tail_n
);

  localparam int unsigned TOP = WIDTH - 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg    <= '0;
      tail   <= 1'b0;
      tail_n <= 1'b1;
    end else begin
      unique case (op)
        OP_LOAD: begin
          stg    <= par;
          tail   <= par[TOP];
          tail_n <= ~par[TOP];
        end
        OP_SHIFT: begin
          stg    <= {stg[TOP-1:0], ser};
          tail   <= stg[TOP-1];
          tail_n <= ~stg[TOP-1];
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/psr_shreg.sv
module psr_shreg
  import psr_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = SYNC_DEFAULT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk_in,
  input  logic             inhib_in,
  input  logic             load_n_in,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic             q_out,
  output logic             q_out_n
);

  // Bundle layout: {par, ser, load_n, inhib, sclk}
  localparam int unsigned BW = WIDTH + 4;
  localparam logic [BW-1:0] BUS_RST = {{WIDTH{1'b0}}, 1'b0, 1'b1, 1'b1, 1'b1};

  logic [BW-1:0]    bus_raw;
  logic [BW-1:0]    bus_s;
  logic             sclk_s;
  logic             inhib_s;
  logic             ld_n_s;
  logic             ser_s;
  logic [WIDTH-1:0] par_s;
  logic             shift_ev;
  stage_op_e        op;
  logic [WIDTH-1:0] stg_q;

  assign bus_raw = {par_in, ser_in, load_n_in, inhib_in, sclk_in};

  psr_sync #(
    .W      (BW),
    .STAGES (SYNC_STAGES),
    .RST_VAL(BUS_RST)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  (bus_raw),
    .q  (bus_s)
  );

  assign sclk_s  = bus_s[0];
  assign inhib_s = bus_s[1];
  assign ld_n_s  = bus_s[2];
  assign ser_s   = bus_s[3];
  assign par_s   = bus_s[BW-1:4];

  psr_gate_edge u_edge (
    .clk     (clk),
    .rst     (rst),
    .sclk_s  (sclk_s),
    .inhib_s (inhib_s),
    .shift_ev(shift_ev)
  );

  assign op = pick_op(ld_n_s, shift_ev);

  psr_stages #(.WIDTH(WIDTH)) u_stages (
    .clk   (clk),
    .rst   (rst),
    .op    (op),
    .ser   (ser_s),
    .par   (par_s),
    .stg   (stg_q),
    .tail  (q_out),
    .tail_n(q_out_n)
  );

endmodule

// File: rtl/psr_shreg_chk.sv
module psr_shreg_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             q_out,
  input logic             q_out_n,
  input logic [WIDTH-1:0] stg,
  input logic             ld_n_s,
  input logic             ser_s,
  input logic [WIDTH-1:0] par_s,
  input logic             shift_ev
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (stg == '0 && !q_out && q_out_n));

  // R8
  complement_chk: assert property (@(posedge clk) disable iff (rst)
    q_out_n == !q_out);

  // R2
  load_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !ld_n_s |=> stg == $past(par_s));

  // R10
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (!ld_n_s && shift_ev) |=> q_out == $past(par_s[WIDTH-1]));

  // R7
  shift_move_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_n_s && shift_ev) |=> stg == {$past(stg[WIDTH-2:0]), $past(ser_s)});

  // R7
  tail_match_chk: assert property (@(posedge clk) disable iff (rst)
    q_out == stg[WIDTH-1]);

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_n_s && !shift_ev) |=> $stable(stg));

endmodule

bind psr_shreg psr_shreg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .q_out   (q_out),
  .q_out_n (q_out_n),
  .stg     (stg_q),
  .ld_n_s  (ld_n_s),
  .ser_s   (ser_s),
  .par_s   (par_s),
  .shift_ev(shift_ev)
);

// File: tb/psr_shreg_tb.sv
module psr_shreg_tb;

  localparam int W    = 8;
  localparam int SYNC = 2;

  logic         clk = 0;
  logic         rst = 1;
  logic         sclk_in = 1;
  logic         inhib_in = 0;
  logic         load_n_in = 1;
  logic         ser_in = 0;
  logic [W-1:0] par_in = '0;
  logic         q_out;
  logic         q_out_n;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  string phase = "R1";

  always #10 clk = ~clk;

  psr_shreg #(.WIDTH(W), .SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rst(rst), .sclk_in(sclk_in), .inhib_in(inhib_in),
    .load_n_in(load_n_in), .ser_in(ser_in), .par_in(par_in),
    .q_out(q_out), .q_out_n(q_out_n)
  );

  // Behavioural reference: inputs delayed through a queue, stages as a vector.
  typedef struct packed {
    logic sc; logic ih; logic ld; logic sr; logic [W-1:0] pr;
  } smp_t;
  localparam smp_t IDLE = '{sc: 1'b1, ih: 1'b1, ld: 1'b1, sr: 1'b0, pr: '0};

  smp_t         hist[$];
  logic [W-1:0] mreg = '0;
  logic         mprev = 1'b1;

  always @(posedge clk) begin
    smp_t d;
    logic g;
    cycles++;
    if (rst) begin
      hist.delete();
      mreg  <= '0;
      mprev <= 1'b1;
    end else begin
      hist.push_back('{sc: sclk_in, ih: inhib_in, ld: load_n_in, sr: ser_in, pr: par_in});
      if (hist.size() > SYNC) d = hist.pop_front();
      else                    d = IDLE;
      g = d.sc | d.ih;
      if (!d.ld)             mreg <= d.pr;
      else if (g && !mprev)  mreg <= {mreg[W-2:0], d.sr};
      mprev <= g;
    end
  end

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0b expected=%0b at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (!rst) begin
      check({phase, " model"}, q_out, mreg[W-1]);
      check("R8 complement", q_out_n, ~q_out);
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_sclk();
    sclk_in = 0; idle(4);
    sclk_in = 1; idle(4);
  endtask

  task automatic pulse_inhib();
    inhib_in = 0; idle(4);
    inhib_in = 1; idle(4);
  endtask

  task automatic do_load(logic [W-1:0] v);
    par_in = v; load_n_in = 0; idle(4);
    load_n_in = 1; idle(4);
  endtask

  initial begin
    logic [W-1:0] pat;
    // R1: reset with the shift clock already high
    idle(3);
    rst = 0;
    idle(6);
    check("R1 q_out after reset", q_out, 1'b0);
    check("R1 q_out_n after reset", q_out_n, 1'b1);

    // R2: load follows the parallel word while clocks toggle
    phase = "R2";
    par_in = 8'hB4; load_n_in = 0; inhib_in = 0;
    sclk_in = 0; idle(4); sclk_in = 1; idle(4);
    check("R2 load bit7", q_out, 1'b1);
    par_in = 8'h2D; ser_in = 1; idle(4);
    check("R2 follow new word", q_out, 1'b0);

    // R7/R4: load then shift out in H..A order
    phase = "R7";
    pat = 8'hA5;
    sclk_in = 1; ser_in = 1;
    do_load(pat);
    for (int i = 0; i < W; i++) begin
      check($sformatf("R7 serial bit %0d", i), q_out, pat[W-1-i]);
      pulse_sclk();
    end
    check("R7 serial fill after drain", q_out, 1'b1);

    // R4: single clock edge gives exactly one shift
    phase = "R4";
    ser_in = 0;
    do_load(8'h80);
    pulse_sclk();
    check("R4 one shift", q_out, 1'b0);

    // R3: parallel word ignored with load high
    phase = "R3";
    do_load(8'h40);
    par_in = 8'hFF; idle(6);
    check("R3 par ignored", q_out, 1'b0);
    pulse_sclk();
    check("R3 shifted stored bit", q_out, 1'b1);

    // R6: inhibit high stalls sclk toggling
    phase = "R6";
    do_load(8'h80);
    inhib_in = 1;
    sclk_in = 0; idle(4); sclk_in = 1; idle(4);
    sclk_in = 0; idle(4);
    check("R6 stall under inhibit", q_out, 1'b1);

    // R5: inhibit acts as clock while sclk low
    phase = "R5";
    pulse_inhib();
    check("R5 inhibit edge shifts", q_out, 1'b0);
    inhib_in = 0; sclk_in = 1; idle(4);

    // R10: load pulse coincides with gated clock edge
    phase = "R10";
    do_load(8'hC0);
    sclk_in = 0; idle(4);
    sclk_in = 1; load_n_in = 0; par_in = 8'h7C;
    idle(1);
    load_n_in = 1; idle(5);
    check("R10 load wins", q_out, 1'b0);
    pulse_sclk();
    check("R10 next shift", q_out, 1'b1);

    // R9: latency of an input change
    phase = "R9";
    par_in = 8'h00; load_n_in = 0; idle(5);
    par_in = 8'h80;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R9 before third edge", q_out, 1'b0);
    @(negedge clk);
    check("R9 at third edge", q_out, 1'b1);
    load_n_in = 1; idle(4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    failures++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule